// File: doc/BRIEF.md
# Stored-Program Digit Sequencer

This block is a very small stored-program processor. It steps through a 32-word program held in a combinational ROM and drives a 4-bit register that carries decimal digits out of the block. The program is fixed when the design is elaborated, through a packed vector parameter. Changing the sequence of digits therefore means changing that parameter, not the logic.

Every enabled clock runs exactly one instruction. An instruction word is 8 bits:

- a 2-bit opcode in bits [7:6];
- bit [5], which is unused;
- a 5-bit operand in bits [4:0].

The four opcodes are:

- 00 writes a digit into the output register.
- 01 loads the program counter with an absolute target.
- 10 replaces the output register with its bitwise complement.
- 11 only advances the counter.

A jump to its own address parks the processor in a halt loop. A run-enable input freezes all state while it is low.

The output is a plain level with no handshake. It holds the most recent value until an instruction changes it.

Top module: `digit_seq_cpu`

## Requirements
- R1: A synchronous active-high reset sets both the program counter and the output register to 0, so execution begins at address 0.
- R2: With run enable high and no jump taken, the counter rises by one per clock and wraps from address 31 to address 0.
- R3: Opcode 00 loads operand bits [3:0] into the output register on the next clock.
- R4: Opcode 01 loads operand bits [4:0] into the counter on the next clock. The instruction at that target runs in the following cycle, with no extra cycle spent on the jump.
- R5: Opcode 10 sets the output register to the one's complement of its current value, and its operand bits have no effect.
- R6: Opcode 11 advances the counter and leaves the output register unchanged.
- R7: While run enable is low, the counter and the output register both keep their values.
- R8: A jump leaves the output register unchanged.
- R9: A jump whose target is its own address holds the counter and the output register stable for as long as run enable stays high.
- R10: When address 0 holds a jump to 16, a program placed at address 16 onward runs correctly after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | High to execute one instruction per clock; low to freeze |
| dout | output | 4 | Output digit register |

## Verification
The assertions assume that reset is held high through the first rising clock edge, so that the `$past` values they compare against are defined. They also assume that `rst` and `run_en` change only away from the active edge.

The bench drives both inputs on the falling edge, and it starts with two cycles of reset. The program is fixed at elaboration, so the stimulus stays within the opcode encodings the assertions decode.

Run enable is varied freely, in long high runs and in gapped patterns. A second reset is applied in the middle of a run.

// File: rtl/digit_seq_pkg.sv
package digit_seq_pkg;

  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 4;
  localparam int OPC_W   = 2;
  localparam int INSTR_W = OPC_W + 1 + ADDR_W;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int PROG_W  = DEPTH * INSTR_W;

  typedef enum logic [OPC_W-1:0] {
    OP_PUT  = 2'b00,
    OP_JUMP = 2'b01,
    OP_INV  = 2'b10,
    OP_IDLE = 2'b11
  } opcode_e;

  function automatic logic [INSTR_W-1:0] encode(opcode_e op, logic [ADDR_W-1:0] arg);
    return {op, 1'b0, arg};
  endfunction

  // Default image: a jump at address 0 to a short digit program at 16,
  // which ends in a self-jump.
  function automatic logic [PROG_W-1:0] default_image();
    logic [PROG_W-1:0] img;
    img = '0;
    for (int a = 0; a < DEPTH; a++)
      img[a*INSTR_W +: INSTR_W] = encode(OP_IDLE, '0);
    img[0*INSTR_W  +: INSTR_W] = encode(OP_JUMP, 5'd16);
    img[16*INSTR_W +: INSTR_W] = encode(OP_PUT, 5'd4);
    img[17*INSTR_W +: INSTR_W] = encode(OP_PUT, 5'd2);
    img[18*INSTR_W +: INSTR_W] = encode(OP_INV, 5'd0);
    img[19*INSTR_W +: INSTR_W] = encode(OP_PUT, 5'd8);
    img[20*INSTR_W +: INSTR_W] = encode(OP_JUMP, 5'd20);
    return img;
  endfunction

endpackage

// File: rtl/digit_seq_pc.sv
module digit_seq_pc
  import digit_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic              load,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] pc_q
);

  always_ff @(posedge clk) begin
    if (rst)
      pc_q <= '0;
    else if (step_en)
      pc_q <= load ? target : pc_q + 1'b1;
  end

endmodule

// File: rtl/digit_seq_rom.sv
module digit_seq_rom
  import digit_seq_pkg::*;
#(
  parameter logic [PROG_W-1:0] IMAGE = default_image()
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [INSTR_W-1:0] word
);

  logic [INSTR_W-1:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    assign cells[g] = IMAGE[g*INSTR_W +: INSTR_W];
  end

  assign word = cells[addr];

endmodule

// File: rtl/digit_seq_decode.sv
module digit_seq_decode
  import digit_seq_pkg::*;
(
  input  logic [INSTR_W-1:0] word,
  output logic               jump_ld,
  output logic               put_ld,
  output logic               inv_en,
  output logic [ADDR_W-1:0]  target,
  output logic [DATA_W-1:0]  digit
);

  opcode_e op;
  logic    spare_unused;

  assign op           = opcode_e'(word[INSTR_W-1 -: OPC_W]);
  assign spare_unused = word[ADDR_W];
  assign target       = word[ADDR_W-1:0];
  assign digit        = word[DATA_W-1:0];

  always_comb begin
    jump_ld = 1'b0;
    put_ld  = 1'b0;
    inv_en  = 1'b0;
    unique case (op)
      OP_PUT:  put_ld  = 1'b1;
      OP_JUMP: jump_ld = 1'b1;
      OP_INV:  inv_en  = 1'b1;
      OP_IDLE: ;
    endcase
  end

endmodule

// File: rtl/digit_seq_outreg.sv
module digit_seq_outreg
  import digit_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic              put_ld,
  input  logic              inv_en,
  input  logic [DATA_W-1:0] digit,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (step_en) begin
      if (put_ld)
        q <= digit;
      else if (inv_en)
        q <= ~q;
    end
  end

endmodule

// File: rtl/digit_seq_cpu.sv
module digit_seq_cpu
  import digit_seq_pkg::*;
#(
  parameter logic [PROG_W-1:0] PROGRAM = default_image()
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  output logic [DATA_W-1:0] dout
);

  logic [ADDR_W-1:0]  pc_q;
  logic [INSTR_W-1:0] instr_w;
  logic               jump_ld;
  logic               put_ld;
  logic               inv_en;
  logic [ADDR_W-1:0]  target;
  logic [DATA_W-1:0]  digit;

  digit_seq_pc u_pc (
    .clk     (clk),
    .rst     (rst),
    .step_en (run_en),
    .load    (jump_ld),
    .target  (target),
    .pc_q    (pc_q)
  );

  digit_seq_rom #(.IMAGE(PROGRAM)) u_rom (
    .addr (pc_q),
    .word (instr_w)
  );

  digit_seq_decode u_dec (
    .word    (instr_w),
    .jump_ld (jump_ld),
    .put_ld  (put_ld),
    .inv_en  (inv_en),
    .target  (target),
    .digit   (digit)
  );

  digit_seq_outreg u_out (
    .clk     (clk),
    .rst     (rst),
    .step_en (run_en),
    .put_ld  (put_ld),
    .inv_en  (inv_en),
    .digit   (digit),
    .q       (dout)
  );

endmodule

// File: rtl/digit_seq_chk.sv
module digit_seq_chk
  import digit_seq_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               run_en,
  input logic [ADDR_W-1:0]  pc,
  input logic [INSTR_W-1:0] instr,
  input logic [DATA_W-1:0]  dout
);

  logic [OPC_W-1:0] op;
  logic             spare_unused;
  assign op           = instr[INSTR_W-1 -: OPC_W];
  assign spare_unused = instr[ADDR_W];

  p_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> ($stable(pc) && $stable(dout)));

  p_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (run_en && op != 2'b01) |=> pc == ADDR_W'($past(pc) + 1'b1));

  p_jump_r4: assert property (@(posedge clk) disable iff (rst)
    (run_en && op == 2'b01) |=> pc == $past(instr[ADDR_W-1:0]));

  p_put_r3: assert property (@(posedge clk) disable iff (rst)
    (run_en && op == 2'b00) |=> dout == $past(instr[DATA_W-1:0]));

  p_invert_r5: assert property (@(posedge clk) disable iff (rst)
    (run_en && op == 2'b10) |=> dout == ~$past(dout));

  p_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (run_en && op == 2'b11) |=> $stable(dout));

  p_jump_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    (run_en && op == 2'b01) |=> $stable(dout));

  p_halt_r9: assert property (@(posedge clk) disable iff (rst)
    (run_en && op == 2'b01 && instr[ADDR_W-1:0] == pc) |=> $stable(pc));

endmodule

bind digit_seq_cpu digit_seq_chk chk_i (
  .clk    (clk),
  .rst    (rst),
  .run_en (run_en),
  .pc     (pc_q),
  .instr  (instr_w),
  .dout   (dout)
);

// File: tb/digit_seq_cpu_tb_top.sv
module digit_seq_cpu_tb_top;

  localparam int AW = 5;
  localparam int IW = 8;
  localparam int N  = 32;

  function automatic logic [7:0] ins(logic [1:0] op, logic [4:0] arg);
    return {op, 1'b0, arg};
  endfunction

  // Boot image: 0 jumps to 16; program at 16..24, ends in self-jump.
  function automatic logic [N*IW-1:0] boot_img();
    logic [N*IW-1:0] v;
    for (int a = 0; a < N; a++) v[a*IW +: IW] = ins(2'b00, 5'd15);
    v[0*IW  +: IW] = ins(2'b01, 5'd16);
    v[16*IW +: IW] = ins(2'b00, 5'd3);
    v[17*IW +: IW] = ins(2'b00, 5'd1);
    v[18*IW +: IW] = ins(2'b10, 5'h1F);
    v[19*IW +: IW] = ins(2'b11, 5'd6);
    v[20*IW +: IW] = ins(2'b00, 5'd9);
    v[21*IW +: IW] = ins(2'b01, 5'd23);
    v[22*IW +: IW] = ins(2'b00, 5'd0);
    v[23*IW +: IW] = ins(2'b00, 5'd7);
    v[24*IW +: IW] = ins(2'b01, 5'd24);
    return v;
  endfunction

  // Wrap image: digit a%10 at 0..29, invert at 30, idle at 31.
  function automatic logic [N*IW-1:0] wrap_img();
    logic [N*IW-1:0] v;
    for (int a = 0; a < 30; a++) v[a*IW +: IW] = ins(2'b00, 5'(a % 10));
    v[30*IW +: IW] = ins(2'b10, 5'd0);
    v[31*IW +: IW] = ins(2'b11, 5'd0);
    return v;
  endfunction

  localparam logic [N*IW-1:0] IMG_B = boot_img();
  localparam logic [N*IW-1:0] IMG_W = wrap_img();

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run_en = 1'b0;
  logic [3:0] dout_b, dout_w;

  always #2 clk = ~clk;

  digit_seq_cpu #(.PROGRAM(IMG_B)) dut_i (.clk(clk), .rst(rst), .run_en(run_en), .dout(dout_b));
  digit_seq_cpu #(.PROGRAM(IMG_W)) dut_w (.clk(clk), .rst(rst), .run_en(run_en), .dout(dout_w));

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [AW-1:0] mpc [2];
  logic [3:0]    mout [2];

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] fetch(int k, logic [AW-1:0] a);
    return (k == 0) ? IMG_B[a*IW +: IW] : IMG_W[a*IW +: IW];
  endfunction

  task automatic step(input logic en, input logic r);
    string tag [2];
    @(negedge clk);
    run_en = en;
    rst = r;
    @(posedge clk);
    for (int k = 0; k < 2; k++) begin
      logic [7:0] w;
      w = fetch(k, mpc[k]);
      if (r) begin
        mpc[k] = '0; mout[k] = '0; tag[k] = "R1 reset";
      end else if (!en) begin
        tag[k] = "R7 frozen";
      end else begin
        case (w[7:6])
          2'b00: begin mout[k] = w[3:0]; mpc[k] = mpc[k] + 1'b1; tag[k] = "R3 put"; end
          2'b01: begin
            tag[k] = (w[4:0] == mpc[k]) ? "R9 halt" : (k == 0 && mpc[k] == 0) ? "R10 boot jump" : "R4/R8 jump";
            mpc[k] = w[4:0];
          end
          2'b10: begin mout[k] = ~mout[k]; mpc[k] = mpc[k] + 1'b1; tag[k] = "R5 invert"; end
          default: begin
            tag[k] = (mpc[k] == 5'd31) ? "R2 wrap" : "R6 idle";
            mpc[k] = mpc[k] + 1'b1;
          end
        endcase
        if (k == 1 && w[7:6] == 2'b00) tag[k] = "R2 sequential";
      end
    end
    #1;
    check(dout_b, mout[0], tag[0]);
    check(dout_w, mout[1], tag[1]);
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin mpc[k] = '0; mout[k] = '0; end
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    // R1: reset state, also with run enable high
    check(dout_b, 4'd0, "R1 reset value");
    // R10: boot jump then program at 16, ending in halt (R9)
    for (int i = 0; i < 16; i++) step(1'b1, 1'b0);
    check(dout_b, 4'd7, "R9 halt digit");
    // R7: gapped enable pattern across a full wrap (R2)
    for (int i = 0; i < 60; i++) step(1'(i % 3 != 0), 1'b0);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0);
    for (int i = 0; i < 70; i++) step(1'b1, 1'b0);
    // R1: reset mid-run, then restart from address 0
    step(1'b1, 1'b1);
    check(dout_w, 4'd0, "R1 mid-run reset");
    for (int i = 0; i < 40; i++) step(1'(i % 2), 1'b0);
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0);
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #40000;
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule